// File: doc/BRIEF.md
# Masked Wide-Word Register File

This block holds a small set of wide data registers, each paired with a byte-granular mask register. It sits beside a unit that corrupts selected bytes of a data word. A wide memory read fills a data register. A store port exposes any data register so it can be written back to memory. Two immediate operations build each mask: one sets the upper half and the other sets the lower half.

A fuzz read selects one register and presents its data and mask together on the fuzz output lines, combinationally. When the fuzz unit returns a result with `wb_valid_i` high, the result is captured on the clock edge into the register currently selected for fuzzing. The write-back can therefore only return to the register the operands came from.

If a memory load and a fuzz write-back hit the same register in the same cycle, the write-back takes priority. Reset clears every data register and every mask. A mask left at zero marks no byte for corruption.

Top module: `mwrf_top`

## Requirements
- R1: After reset deassertion every data register and every mask register reads as zero on both the store port and the fuzz port.
- R2: On a rising clock edge with `ld_valid_i` high, data register `ld_idx_i` takes the value of `ld_data_i`, unless R8 applies.
- R3: `st_data_o` presents the contents of data register `st_idx_i` combinationally, in the same cycle the index is applied.
- R4: On a rising clock edge with `msk_valid_i` high, `msk_hi_i`=1 writes `msk_imm_i` into bits [31:16] of mask `msk_idx_i`, and `msk_hi_i`=0 writes it into bits [15:0]. The other half of that mask keeps its value.
- R5: Mask writes never change any data register, and loads and write-backs never change any mask register.
- R6: `fz_data_o` and `fz_mask_o` present the data and the mask of register `fz_idx_i` together, combinationally.
- R7: On a rising clock edge with `wb_valid_i` high, `wb_data_i` is written into data register `fz_idx_i`.
- R8: When a load and a write-back target the same register on the same edge, the register takes `wb_data_i`. When they target different registers, both writes happen.
- R9: A register not addressed by an asserted write strobe keeps its value across a clock edge, whatever the data and index inputs carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ld_valid_i | input | 1 | Load strobe from wide memory |
| ld_idx_i | input | 3 | Load target register |
| ld_data_i | input | 256 | Load data |
| st_idx_i | input | 3 | Store source register |
| st_data_o | output | 256 | Store data toward memory |
| msk_valid_i | input | 1 | Mask half write strobe |
| msk_hi_i | input | 1 | 1 selects mask bits [31:16], 0 selects bits [15:0] |
| msk_idx_i | input | 3 | Mask target register |
| msk_imm_i | input | 16 | Immediate half-mask value |
| fz_idx_i | input | 3 | Fuzz source and write-back target register |
| fz_data_o | output | 256 | Data sent to fuzz unit |
| fz_mask_o | output | 32 | Byte mask sent to fuzz unit |
| wb_valid_i | input | 1 | Fuzz result write-back strobe |
| wb_data_i | input | 256 | Fuzz result |

## Verification
The bench builds the block with its default parameters: eight registers of 256 bits and 32-bit masks. At this size every register can be loaded, masked half by half, fuzzed and written back in a full sweep. After each operation the bench reads all eight registers through both read ports, so any stray write to a neighbouring register becomes visible. The small index space also lets the bench place a load and a write-back on the same register and on different registers in the same cycle. Expected write-back values are computed arithmetically from the byte-expanded mask and a generated pattern.

// File: rtl/mwrf_pkg.sv
package mwrf_pkg;
  typedef enum logic {
    MSK_LO = 1'b0,
    MSK_HI = 1'b1
  } msk_half_e;
endpackage

// File: rtl/mwrf_rd_mux.sv
module mwrf_rd_mux #(
  parameter int N = 8,
  parameter int W = 256,
  localparam int SW = $clog2(N)
) (
  input  logic [SW-1:0]       sel_i,
  input  logic [N-1:0][W-1:0] vec_i,
  output logic [W-1:0]        dat_o
);
  always_comb begin
    dat_o = '0;
    for (int i = 0; i < N; i++) begin
      if (sel_i == SW'(i)) dat_o = vec_i[i];
    end
  end
endmodule

// File: rtl/mwrf_data_bank.sv
module mwrf_data_bank #(
  parameter int N = 8,
  parameter int W = 256,
  localparam int IW = $clog2(N)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                ld_valid_i,
  input  logic [IW-1:0]       ld_idx_i,
  input  logic [W-1:0]        ld_data_i,
  input  logic                wb_valid_i,
  input  logic [IW-1:0]       wb_idx_i,
  input  logic [W-1:0]        wb_data_i,
  output logic [N-1:0][W-1:0] regs_o
);
  logic [N-1:0][W-1:0] regs_q;

  for (genvar g = 0; g < N; g++) begin : g_reg
    logic wb_hit, ld_hit;
    assign wb_hit = wb_valid_i && (wb_idx_i == IW'(g));
    assign ld_hit = ld_valid_i && (ld_idx_i == IW'(g));
    // write-back outranks a load to the same register
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     regs_q[g] <= '0;
      else if (wb_hit) regs_q[g] <= wb_data_i;
      else if (ld_hit) regs_q[g] <= ld_data_i;
    end
  end

  assign regs_o = regs_q;

  a_r8_wb_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wb_valid_i && ld_valid_i && wb_idx_i == ld_idx_i)
    |=> regs_q[$past(wb_idx_i)] == $past(wb_data_i));

  a_r2_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ld_valid_i && !(wb_valid_i && wb_idx_i == ld_idx_i))
    |=> regs_q[$past(ld_idx_i)] == $past(ld_data_i));

  a_r7_wb: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wb_valid_i |=> regs_q[$past(wb_idx_i)] == $past(wb_data_i));

  a_r9_idle_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ld_valid_i && !wb_valid_i) |=> $stable(regs_q));
endmodule

// File: rtl/mwrf_mask_bank.sv
module mwrf_mask_bank
  import mwrf_pkg::*;
#(
  parameter int N = 8,
  parameter int MW = 32,
  localparam int IW = $clog2(N),
  localparam int HW = MW / 2
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 msk_valid_i,
  input  msk_half_e            msk_half_i,
  input  logic [IW-1:0]        msk_idx_i,
  input  logic [HW-1:0]        msk_imm_i,
  output logic [N-1:0][MW-1:0] masks_o
);
  logic [N-1:0][MW-1:0] masks_q;

  for (genvar g = 0; g < N; g++) begin : g_msk
    logic hit;
    assign hit = msk_valid_i && (msk_idx_i == IW'(g));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        masks_q[g] <= '0;
      end else if (hit) begin
        if (msk_half_i == MSK_HI) masks_q[g][MW-1:HW] <= msk_imm_i;
        else                      masks_q[g][HW-1:0]  <= msk_imm_i;
      end
    end
  end

  assign masks_o = masks_q;

  a_r4_hi_keeps_lo: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (msk_valid_i && msk_half_i == MSK_HI)
    |=> masks_q[$past(msk_idx_i)][HW-1:0] == $past(masks_q[msk_idx_i][HW-1:0]));

  a_r4_lo_keeps_hi: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (msk_valid_i && msk_half_i == MSK_LO)
    |=> masks_q[$past(msk_idx_i)][MW-1:HW] == $past(masks_q[msk_idx_i][MW-1:HW]));

  a_r4_written: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (msk_valid_i && msk_half_i == MSK_HI)
    |=> masks_q[$past(msk_idx_i)][MW-1:HW] == $past(msk_imm_i));

  a_r9_mask_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !msk_valid_i |=> $stable(masks_q));
endmodule

// File: rtl/mwrf_top.sv
module mwrf_top
  import mwrf_pkg::*;
#(
  parameter int NUM_REGS = 8,
  parameter int DATA_W   = 256,
  parameter int BYTE_W   = 8,
  localparam int IDX_W   = $clog2(NUM_REGS),
  localparam int MASK_W  = DATA_W / BYTE_W,
  localparam int HALF_W  = MASK_W / 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ld_valid_i,
  input  logic [IDX_W-1:0]  ld_idx_i,
  input  logic [DATA_W-1:0] ld_data_i,
  input  logic [IDX_W-1:0]  st_idx_i,
  output logic [DATA_W-1:0] st_data_o,
  input  logic              msk_valid_i,
  input  logic              msk_hi_i,
  input  logic [IDX_W-1:0]  msk_idx_i,
  input  logic [HALF_W-1:0] msk_imm_i,
  input  logic [IDX_W-1:0]  fz_idx_i,
  output logic [DATA_W-1:0] fz_data_o,
  output logic [MASK_W-1:0] fz_mask_o,
  input  logic              wb_valid_i,
  input  logic [DATA_W-1:0] wb_data_i
);
  logic [NUM_REGS-1:0][DATA_W-1:0] regs;
  logic [NUM_REGS-1:0][MASK_W-1:0] masks;
  msk_half_e                       half;

  assign half = msk_hi_i ? MSK_HI : MSK_LO;

  mwrf_data_bank #(.N(NUM_REGS), .W(DATA_W)) u_data (
    .clk_i, .rst_ni,
    .ld_valid_i, .ld_idx_i, .ld_data_i,
    .wb_valid_i, .wb_idx_i(fz_idx_i), .wb_data_i,
    .regs_o(regs)
  );

  mwrf_mask_bank #(.N(NUM_REGS), .MW(MASK_W)) u_mask (
    .clk_i, .rst_ni,
    .msk_valid_i, .msk_half_i(half), .msk_idx_i, .msk_imm_i,
    .masks_o(masks)
  );

  mwrf_rd_mux #(.N(NUM_REGS), .W(DATA_W)) u_st_mux (
    .sel_i(st_idx_i), .vec_i(regs), .dat_o(st_data_o)
  );

  mwrf_rd_mux #(.N(NUM_REGS), .W(DATA_W)) u_fz_mux (
    .sel_i(fz_idx_i), .vec_i(regs), .dat_o(fz_data_o)
  );

  mwrf_rd_mux #(.N(NUM_REGS), .W(MASK_W)) u_fm_mux (
    .sel_i(fz_idx_i), .vec_i(masks), .dat_o(fz_mask_o)
  );

  a_r5_mask_only_keeps_data: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (msk_valid_i && !ld_valid_i && !wb_valid_i) |=> $stable(regs));

  a_r5_data_keeps_masks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((ld_valid_i || wb_valid_i) && !msk_valid_i) |=> $stable(masks));

  a_r6_same_port: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wb_valid_i && !msk_valid_i) |=> $stable(fz_mask_o) || fz_idx_i != $past(fz_idx_i));
endmodule

// File: tb/sim_mwrf_top.sv
`timescale 1ns/1ps
module sim_mwrf_top;
  localparam int N = 8, DW = 256, MW = 32, HW = 16, IW = 3;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic ld_valid_i = 0, msk_valid_i = 0, msk_hi_i = 0, wb_valid_i = 0;
  logic [IW-1:0] ld_idx_i = '0, st_idx_i = '0, msk_idx_i = '0, fz_idx_i = '0;
  logic [DW-1:0] ld_data_i = '0, wb_data_i = '0, st_data_o, fz_data_o;
  logic [HW-1:0] msk_imm_i = '0;
  logic [MW-1:0] fz_mask_o;

  logic [DW-1:0] exp_d [N];
  logic [MW-1:0] exp_m [N];
  int tests = 0, fails = 0;

  always #4 clk_i = ~clk_i;

  mwrf_top u0 (.*);

  function automatic logic [DW-1:0] pat(int r, int s);
    logic [DW-1:0] v;
    for (int i = 0; i < DW/32; i++)
      v[i*32 +: 32] = (32'h9E3779B9 * (r + 1)) ^ (32'h01000193 * (s + 7) + i);
    return v;
  endfunction

  function automatic logic [DW-1:0] expand(logic [MW-1:0] m);
    logic [DW-1:0] v;
    for (int i = 0; i < MW; i++) v[i*8 +: 8] = {8{m[i]}};
    return v;
  endfunction

  task automatic chk(string req, logic [DW-1:0] act, logic [DW-1:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk_i);
    #1;
    ld_valid_i = 0; msk_valid_i = 0; wb_valid_i = 0;
    #1;
  endtask

  // read every register through store and fuzz ports
  task automatic check_all(string req);
    for (int r = 0; r < N; r++) begin
      st_idx_i = IW'(r); fz_idx_i = IW'(r);
      #1;
      chk({req, " R3 st"}, st_data_o, exp_d[r]);
      chk({req, " R6 fz_data"}, fz_data_o, exp_d[r]);
      chk({req, " R6 fz_mask"}, DW'(fz_mask_o), DW'(exp_m[r]));
    end
  endtask

  initial begin
    #(8 * 20000);
    fails++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    for (int r = 0; r < N; r++) begin exp_d[r] = '0; exp_m[r] = '0; end
    #20 rst_ni = 1'b1;
    #3;
    check_all("R1 reset");

    // R2 loads, R5 masks untouched
    for (int r = 0; r < N; r++) begin
      ld_valid_i = 1; ld_idx_i = IW'(r); ld_data_i = pat(r, 1);
      exp_d[r] = pat(r, 1);
      step();
      check_all("R2 R5 load");
    end

    // R4 mask halves, R5 data untouched
    for (int r = 0; r < N; r++) begin
      msk_valid_i = 1; msk_hi_i = 1; msk_idx_i = IW'(r); msk_imm_i = 16'hA50F ^ HW'(r * 16'h1111);
      exp_m[r][31:16] = msk_imm_i;
      step();
      check_all("R4 R5 hi");
      msk_valid_i = 1; msk_hi_i = 0; msk_idx_i = IW'(r); msk_imm_i = 16'h3C81 + HW'(r);
      exp_m[r][15:0] = msk_imm_i;
      step();
      check_all("R4 lo");
    end
    msk_valid_i = 1; msk_hi_i = 1; msk_idx_i = 3'd3; msk_imm_i = 16'hFFFF;
    exp_m[3][31:16] = 16'hFFFF;
    step();
    check_all("R4 rewrite hi");

    // R7 write-back into fuzz source register
    for (int r = 0; r < N; r++) begin
      fz_idx_i = IW'(r);
      #1;
      wb_valid_i = 1;
      wb_data_i = exp_d[r] ^ (expand(exp_m[r]) & pat(r, 9));
      ld_data_i = pat(r, 99); ld_idx_i = IW'(r); // strobe low: must be ignored
      exp_d[r] = wb_data_i;
      step();
      check_all("R7 R9 wb");
    end

    // R8 collision on the same register: write-back wins
    fz_idx_i = 3'd5; ld_idx_i = 3'd5;
    ld_valid_i = 1; ld_data_i = pat(5, 40);
    wb_valid_i = 1; wb_data_i = pat(5, 41);
    exp_d[5] = pat(5, 41);
    step();
    check_all("R8 same");

    // R8 different registers both land
    fz_idx_i = 3'd6; ld_idx_i = 3'd2;
    ld_valid_i = 1; ld_data_i = pat(2, 50);
    wb_valid_i = 1; wb_data_i = pat(6, 51);
    exp_d[2] = pat(2, 50); exp_d[6] = pat(6, 51);
    step();
    check_all("R8 diff");

    // R9 no strobe: everything holds
    ld_data_i = '1; wb_data_i = '1; msk_imm_i = '1;
    step();
    step();
    check_all("R9 idle");

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule